// File: doc/BRIEF.md
# Periodic Wake Timer with Staged Sleep Sequencer

This block wakes a low-power radio at a programmable interval and sequences the power of its oscillator, synthesizer and power amplifier. A prescaler divides the system clock into a millisecond tick. A period counter runs from that tick and fires a one-cycle wake pulse every mantissa × 2^exponent milliseconds. Each pulse also latches an active-low interrupt, which a status read clears. A duty-window option holds a receiver enable high for the opening (2D+1) × 2^exponent milliseconds of every period. This gives an on fraction of (2D+1)/mantissa.

The timer takes its configuration when its enable rises and keeps it for as long as the enable stays high. To make new settings take effect, software clears the enable and sets it again. The power sequencer runs in automatic or manual mode. In automatic mode a transmit command turns all three enables on. A sleep command turns the synthesizer and amplifier off at once and stops the oscillator a programmed number of clock cycles later. In manual mode the three enables follow a direct input vector.

Top module: `wake_sleep_ctrl`

## Requirements
- R1: With the timer enabled and mantissa M nonzero, wake pulses come exactly M × 2^E × CLKS_PER_MS clock cycles apart. The first pulse appears that many cycles after the clock edge that sees the enable high.
- R2: Each wake pulse is one clock cycle wide.
- R3: With M equal to zero, no wake pulse occurs and the receiver enable stays low.
- R4: Mantissa, exponent and duty settings are captured on the first edge that sees the timer enable high. Changes made while the enable stays high have no effect until the enable is cleared and set again. While the enable is low, no wake pulse occurs.
- R5: With the duty window on, the receiver enable is high for the first min((2D+1) × 2^E, M × 2^E) milliseconds of each period and low for the rest.
- R6: With the duty window off, the receiver enable stays low.
- R7: The active-low interrupt falls on the cycle after a wake pulse and stays low until a status-read cycle. A wake pulse present in that same cycle keeps it low.
- R8: In automatic mode, a transmit command sets the oscillator, synthesizer and amplifier enables high on the next edge.
- R9: In automatic mode, a sleep command (with no transmit in the same cycle) clears the synthesizer and amplifier enables on that edge. The oscillator enable stays high for exactly S further cycles, where S is the sleep-cycle count; S = 0 stops it at once.
- R10: A transmit command during the delayed oscillator stop cancels the stop and turns all three enables back on.
- R11: In manual mode, the enables copy the manual vector one edge later, with bit 2 to the oscillator, bit 1 to the synthesizer and bit 0 to the amplifier. Transmit and sleep commands have no effect.
- R12: After reset, wake is low, the interrupt is high (inactive), and the receiver, oscillator, synthesizer and amplifier enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_en_i | input | 1 | Timer enable; a rising level captures the configuration |
| tmr_mant_i | input | 8 | Period mantissa M |
| tmr_exp_i | input | 5 | Period exponent E |
| duty_en_i | input | 1 | Duty-window enable |
| duty_d_i | input | 7 | Duty field D |
| stat_rd_i | input | 1 | Status-read strobe; clears the interrupt |
| auto_mode_i | input | 1 | 1 = command-driven power sequencing, 0 = manual |
| tx_cmd_i | input | 1 | Transmit command strobe |
| sleep_cmd_i | input | 1 | Sleep command strobe |
| sleep_cyc_i | input | 8 | Oscillator stop delay S in clock cycles |
| man_en_i | input | 3 | Manual enables {oscillator, synthesizer, amplifier} |
| wake_o | output | 1 | One-cycle wake pulse |
| irq_n_o | output | 1 | Active-low wake interrupt |
| rx_on_o | output | 1 | Receiver enable from the duty window |
| xo_en_o | output | 1 | Oscillator enable |
| synth_en_o | output | 1 | Synthesizer enable |
| pa_en_o | output | 1 | Power amplifier enable |

## Verification
The bench sweeps mantissa and exponent over a small grid with a four-cycle millisecond and measures the first latency and the following gaps in cycles. An off-by-one in the period compare, or a period counter that does not clear on restart, shows up directly in those numbers. It sweeps the duty field through windows shorter than, equal to and longer than the period. A window that is not clamped, or one that is off by a millisecond, changes the count of receiver-on cycles. It checks oscillator stop delays of zero, one and several cycles, so a countdown that is one cycle off is caught. It also covers a status read that collides with a wake pulse, a configuration change made while the timer runs, and a transmit that cancels a pending shutdown.

// File: rtl/wake_pkg.sv
package wake_pkg;

    localparam int MANT_W = 8;
    localparam int EXP_W  = 5;
    localparam int DUTY_W = 7;
    localparam int SLP_W  = 8;
    // widest millisecond count: mantissa shifted by the largest exponent
    localparam int MS_W   = MANT_W + (1 << EXP_W) - 1;

    typedef struct packed {
        logic [MANT_W-1:0] mant;
        logic [EXP_W-1:0]  expo;
        logic [DUTY_W-1:0] duty;
        logic              duty_en;
    } wake_cfg_t;

    typedef struct packed {
        logic xo;
        logic synth;
        logic pa;
    } pwr_en_t;

    typedef enum logic [1:0] {
        PWR_OFF,
        PWR_ON,
        PWR_DRAIN
    } pwr_state_t;

    function automatic logic [MS_W-1:0] period_ms(input wake_cfg_t c);
        return MS_W'(c.mant) << c.expo;
    endfunction

    function automatic logic [MS_W-1:0] window_ms(input wake_cfg_t c);
        return MS_W'({c.duty, 1'b1}) << c.expo;
    endfunction

endpackage

// File: rtl/wake_prescaler.sv
module wake_prescaler #(
    parameter int CLKS_PER_MS = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic tick_o
);
    localparam int PW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLKS_PER_MS - 1);

    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/wake_period_timer.sv
module wake_period_timer
    import wake_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en_i,
    input  wake_cfg_t cfg_i,
    input  logic      tick_i,
    output logic      run_o,
    output logic      wake_o,
    output logic      rx_on_o
);
    logic            run_q;
    wake_cfg_t       cfg_q;
    logic [MS_W-1:0] ms_q;
    logic            wake_q;
    logic            active;
    logic [MS_W-1:0] last_ms;
    logic [MS_W-1:0] win_ms;

    assign active  = (cfg_q.mant != '0);
    assign last_ms = period_ms(cfg_q) - 1'b1;
    assign win_ms  = window_ms(cfg_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            cfg_q  <= '0;
            ms_q   <= '0;
            wake_q <= 1'b0;
        end else begin
            run_q  <= en_i;
            wake_q <= 1'b0;
            if (en_i && !run_q) begin
                cfg_q <= cfg_i;
                ms_q  <= '0;
            end else if (!run_q) begin
                ms_q <= '0;
            end else if (tick_i && active) begin
                if (ms_q == last_ms) begin
                    ms_q   <= '0;
                    wake_q <= 1'b1;
                end else begin
                    ms_q <= ms_q + 1'b1;
                end
            end
        end
    end

    assign run_o   = run_q;
    assign wake_o  = wake_q;
    assign rx_on_o = run_q && active && cfg_q.duty_en && (ms_q < win_ms);

    // R4: captured settings hold while the enable stays high
    a_r4_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        (run_q && en_i) |=> $stable(cfg_q));

    // R3: no wake while idle or with a zero mantissa
    a_r3_idle_no_wake: assert property (@(posedge clk) disable iff (rst)
        (!run_q || cfg_q.mant == '0) |=> !wake_q);

    // R1: a wake only follows a millisecond tick
    a_r1_wake_on_tick: assert property (@(posedge clk) disable iff (rst)
        (!tick_i) |=> !wake_q);

endmodule

// File: rtl/wake_sleep_seq.sv
module wake_sleep_seq
    import wake_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             auto_i,
    input  logic             tx_i,
    input  logic             sleep_i,
    input  logic [SLP_W-1:0] slp_cyc_i,
    input  pwr_en_t          man_i,
    output pwr_en_t          en_o
);
    pwr_state_t       state_q;
    logic [SLP_W-1:0] cnt_q;
    pwr_en_t          en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PWR_OFF;
            cnt_q   <= '0;
            en_q    <= '0;
        end else if (!auto_i) begin
            en_q    <= man_i;
            cnt_q   <= '0;
            state_q <= (man_i != '0) ? PWR_ON : PWR_OFF;
        end else if (tx_i) begin
            en_q    <= '1;
            cnt_q   <= '0;
            state_q <= PWR_ON;
        end else if (state_q == PWR_DRAIN) begin
            if (cnt_q <= 1) begin
                en_q.xo <= 1'b0;
                cnt_q   <= '0;
                state_q <= PWR_OFF;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (sleep_i) begin
            en_q.synth <= 1'b0;
            en_q.pa    <= 1'b0;
            if (slp_cyc_i == '0 || !en_q.xo) begin
                en_q.xo <= 1'b0;
                state_q <= PWR_OFF;
            end else begin
                cnt_q   <= slp_cyc_i;
                state_q <= PWR_DRAIN;
            end
        end
    end

    assign en_o = en_q;

    // R8: transmit command powers everything up
    a_r8_tx_all_on: assert property (@(posedge clk) disable iff (rst)
        (auto_i && tx_i) |=> (en_q == 3'b111));

    // R9: synthesizer and amplifier drop on the sleep edge
    a_r9_fast_off: assert property (@(posedge clk) disable iff (rst)
        (auto_i && sleep_i && !tx_i && state_q != PWR_DRAIN) |=> (!en_q.synth && !en_q.pa));

    // R9: oscillator held while the countdown has cycles left
    a_r9_xo_held: assert property (@(posedge clk) disable iff (rst)
        (auto_i && !tx_i && state_q == PWR_DRAIN && cnt_q > 1) |=> en_q.xo);

    // R11: manual mode copies the vector
    a_r11_manual_copy: assert property (@(posedge clk) disable iff (rst)
        (!auto_i) |=> (en_q == $past(man_i)));

endmodule

// File: rtl/wake_sleep_ctrl.sv
module wake_sleep_ctrl
    import wake_pkg::*;
#(
    parameter int CLKS_PER_MS = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tmr_en_i,
    input  logic [MANT_W-1:0] tmr_mant_i,
    input  logic [EXP_W-1:0]  tmr_exp_i,
    input  logic              duty_en_i,
    input  logic [DUTY_W-1:0] duty_d_i,
    input  logic              stat_rd_i,
    input  logic              auto_mode_i,
    input  logic              tx_cmd_i,
    input  logic              sleep_cmd_i,
    input  logic [SLP_W-1:0]  sleep_cyc_i,
    input  logic [2:0]        man_en_i,
    output logic              wake_o,
    output logic              irq_n_o,
    output logic              rx_on_o,
    output logic              xo_en_o,
    output logic              synth_en_o,
    output logic              pa_en_o
);
    wake_cfg_t cfg;
    pwr_en_t   man_en;
    pwr_en_t   pwr_en;
    logic      run;
    logic      tick;
    logic      wake;
    logic      irq_q;

    assign cfg = '{mant: tmr_mant_i, expo: tmr_exp_i, duty: duty_d_i, duty_en: duty_en_i};
    assign man_en = '{xo: man_en_i[2], synth: man_en_i[1], pa: man_en_i[0]};

    wake_prescaler #(.CLKS_PER_MS(CLKS_PER_MS)) u_presc (
        .clk    (clk),
        .rst    (rst),
        .run_i  (run),
        .tick_o (tick)
    );

    wake_period_timer u_timer (
        .clk     (clk),
        .rst     (rst),
        .en_i    (tmr_en_i),
        .cfg_i   (cfg),
        .tick_i  (tick),
        .run_o   (run),
        .wake_o  (wake),
        .rx_on_o (rx_on_o)
    );

    wake_sleep_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .auto_i    (auto_mode_i),
        .tx_i      (tx_cmd_i),
        .sleep_i   (sleep_cmd_i),
        .slp_cyc_i (sleep_cyc_i),
        .man_i     (man_en),
        .en_o      (pwr_en)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else if (wake) begin
            irq_q <= 1'b1;
        end else if (stat_rd_i) begin
            irq_q <= 1'b0;
        end
    end

    assign wake_o     = wake;
    assign irq_n_o    = !irq_q;
    assign xo_en_o    = pwr_en.xo;
    assign synth_en_o = pwr_en.synth;
    assign pa_en_o    = pwr_en.pa;

    // R7: a wake always leaves the interrupt asserted
    a_r7_irq_after_wake: assert property (@(posedge clk) disable iff (rst)
        wake |=> !irq_n_o);

    // R7: the interrupt only releases after a status read
    a_r7_irq_release: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_n_o) |-> $past(stat_rd_i));

endmodule

// File: tb/test_wake_sleep_ctrl.sv
module test_wake_sleep_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int C = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tmr_en = 1'b0;
    logic [7:0] mant = 8'd0;
    logic [4:0] expo = 5'd0;
    logic       duty_en = 1'b0;
    logic [6:0] duty_d = 7'd0;
    logic       stat_rd = 1'b0;
    logic       auto_mode = 1'b1;
    logic       tx_cmd = 1'b0;
    logic       sleep_cmd = 1'b0;
    logic [7:0] sleep_cyc = 8'd0;
    logic [2:0] man_en = 3'b000;
    logic wake, irq_n, rx_on, xo, synth, pa;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    wake_sleep_ctrl #(.CLKS_PER_MS(C)) i_wake_sleep_ctrl (
        .clk(clk), .rst(rst), .tmr_en_i(tmr_en), .tmr_mant_i(mant), .tmr_exp_i(expo),
        .duty_en_i(duty_en), .duty_d_i(duty_d), .stat_rd_i(stat_rd),
        .auto_mode_i(auto_mode), .tx_cmd_i(tx_cmd), .sleep_cmd_i(sleep_cmd),
        .sleep_cyc_i(sleep_cyc), .man_en_i(man_en), .wake_o(wake), .irq_n_o(irq_n),
        .rx_on_o(rx_on), .xo_en_o(xo), .synth_en_o(synth), .pa_en_o(pa)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_wake(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!wake && n < 2000);
    endtask

    task automatic restart(input int m, input int r);
        tmr_en = 1'b0;
        @(negedge clk);
        mant = 8'(m);
        expo = 5'(r);
        tmr_en = 1'b1;
    endtask

    task automatic measure_period(input int m, input int r);
        int n;
        int cp;
        cp = m * (1 << r) * C;
        restart(m, r);
        wait_wake(n);
        check("R1 first latency", n, cp + 1);
        @(negedge clk);
        check("R2 pulse width", wake, 0);
        wait_wake(n);
        check("R1 gap", n, cp - 1);
        wait_wake(n);
        check("R1 second gap", n, cp);
    endtask

    task automatic measure_duty(input int d, input bit on, input int expect_ms);
        int n;
        int hi;
        duty_d = 7'(d);
        duty_en = on;
        restart(5, 1);
        wait_wake(n);
        hi = 0;
        for (int i = 0; i < 5 * 2 * C; i++) begin
            if (rx_on) hi++;
            @(negedge clk);
        end
        if (on) check("R5 duty window cycles", hi, expect_ms * C);
        else    check("R6 duty off cycles", hi, 0);
        check("R5 next pulse on time", wake, 1);
    endtask

    task automatic sleep_run(input int s);
        int hi;
        tx_cmd = 1'b1;
        @(negedge clk);
        tx_cmd = 1'b0;
        check("R8 tx all on", {xo, synth, pa}, 3'b111);
        sleep_cyc = 8'(s);
        sleep_cmd = 1'b1;
        @(negedge clk);
        sleep_cmd = 1'b0;
        check("R9 synth/pa off", {synth, pa}, 2'b00);
        hi = 0;
        while (xo && hi < 400) begin
            hi++;
            @(negedge clk);
        end
        check("R9 xo hold cycles", hi, s);
    endtask

    initial begin
        int n;
        int cnt;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12 reset state
        check("R12 reset outputs", {wake, irq_n, rx_on, xo, synth, pa}, 6'b010000);
        rst = 1'b0;
        @(negedge clk);

        // R1/R2 sweep of mantissa and exponent
        foreach (mant_list[i]) ;
        for (int m = 1; m <= 5; m += 2) begin
            for (int r = 0; r <= 2; r++) measure_period(m, r);
        end
        measure_period(2, 3);

        // R7 interrupt behaviour
        restart(2, 0);
        wait_wake(n);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        check("R7 read colliding with wake keeps irq", irq_n, 0);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        check("R7 status read clears irq", irq_n, 1);
        wait_wake(n);
        @(negedge clk);
        check("R7 irq low after wake", irq_n, 0);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;

        // R4 configuration frozen while enabled
        restart(2, 0);
        wait_wake(n);
        check("R4 initial config", n, 2 * C + 1);
        mant = 8'd5;
        wait_wake(n);
        check("R4 change ignored while enabled", n, 2 * C);
        restart(5, 0);
        wait_wake(n);
        check("R4 new config after re-enable", n, 5 * C + 1);
        tmr_en = 1'b0;
        cnt = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (wake) cnt++;
        end
        check("R4 disabled no wake", cnt, 0);

        // R3 zero mantissa
        duty_en = 1'b1;
        duty_d = 7'd3;
        restart(0, 2);
        cnt = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (wake || rx_on) cnt++;
        end
        check("R3 zero mantissa silent", cnt, 0);

        // R5/R6 duty window sweep, M=5 E=1 -> period 10 ms
        measure_duty(0, 1'b1, 2);
        measure_duty(1, 1'b1, 6);
        measure_duty(2, 1'b1, 10);
        measure_duty(3, 1'b1, 10);
        measure_duty(1, 1'b0, 0);
        tmr_en = 1'b0;
        duty_en = 1'b0;

        // R8/R9 sleep sequencing sweep
        auto_mode = 1'b1;
        sleep_run(0);
        sleep_run(1);
        sleep_run(2);
        sleep_run(5);
        sleep_run(17);

        // R10 transmit cancels the delayed stop
        tx_cmd = 1'b1;
        @(negedge clk);
        tx_cmd = 1'b0;
        sleep_cyc = 8'd20;
        sleep_cmd = 1'b1;
        @(negedge clk);
        sleep_cmd = 1'b0;
        repeat (5) @(negedge clk);
        tx_cmd = 1'b1;
        @(negedge clk);
        tx_cmd = 1'b0;
        check("R10 tx restores all", {xo, synth, pa}, 3'b111);
        repeat (30) @(negedge clk);
        check("R10 oscillator not stopped", xo, 1);

        // R11 manual mode
        auto_mode = 1'b0;
        man_en = 3'b101;
        @(negedge clk);
        check("R11 manual copy", {xo, synth, pa}, 3'b101);
        tx_cmd = 1'b1;
        @(negedge clk);
        tx_cmd = 1'b0;
        check("R11 tx ignored", {xo, synth, pa}, 3'b101);
        sleep_cyc = 8'd0;
        sleep_cmd = 1'b1;
        @(negedge clk);
        sleep_cmd = 1'b0;
        check("R11 sleep ignored", {xo, synth, pa}, 3'b101);
        man_en = 3'b010;
        @(negedge clk);
        check("R11 manual copy second", {xo, synth, pa}, 3'b010);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    int mant_list[1] = '{0};

endmodule